// File: doc/BRIEF.md
# Instruction Length Decoder (32-bit x86 encoding)

This block looks at a window of up to fifteen bytes that begins at the first byte of a 32-bit protected-mode x86 instruction. It works out how long that instruction is, and it splits the total into fields: prefix bytes, opcode bytes, the ModR/M byte, the SIB byte, displacement bytes and immediate bytes. A fetch or predecode stage uses these results to find the next instruction boundary and to locate the fields inside the instruction.

The decoder handles the following encodings:

- legacy prefixes;
- the one-byte opcode map;
- the 0F escape to the two-byte map, and the 0F 38 and 0F 3A escapes to the three-byte maps;
- the short encodings that carry no ModR/M byte;
- the two-byte and three-byte VEX prefixes.

Input and output each use a valid/ready handshake. The result is registered, so it appears one cycle after the window is accepted. The invalid flag is raised in these cases:

- the instruction cannot be classified;
- it uses the address-size override;
- its length is more than fifteen bytes;
- it runs past the number of bytes the caller marked as present.

When the invalid flag is raised, the length and every field count read as zero.

Top module: `insn_len_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` is high whenever no result is held or `out_ready` is high. A window accepted on a clock edge gives its result, with `out_valid` high, from that edge onward. While `out_valid` is high and `out_ready` is low, the result stays unchanged and `in_ready` is low.
- R2: Each leading byte from the set F0, F2, F3, 2E, 36, 3E, 26, 64, 65, 66 adds one to the prefix count, in any order and with any repetition.
- R3: Opcode count depends on the escape bytes:
  - A first opcode byte of 0F gives an opcode count of 2.
  - 0F 38 and 0F 3A give an opcode count of 3, and 0F 3A adds a one-byte immediate.
  - In the 0F map, opcodes 80–8F carry a four-byte immediate and no ModR/M byte.
  - In the 0F map, A2 carries neither.
  - In the 0F map, B6 carries a ModR/M byte.
- R4: ModR/M has mod in bits 7:6, reg in bits 5:3 and r/m in bits 2:0. Addressing bytes follow these rules:
  - mod=11 adds nothing.
  - When mod≠11 and r/m=100, a SIB byte follows, whose base field is bits 2:0.
  - mod=01 adds a one-byte displacement.
  - mod=10 adds a four-byte displacement.
  - mod=00 adds a four-byte displacement when r/m=101 without a SIB byte, or when the SIB base is 101.
- R5: These short forms have no ModR/M byte:
  - 40–5F and 90–97 are one byte.
  - B0–B7 carry a one-byte immediate.
  - B8–BF carry a four-byte immediate.
  - In rows 00–3F, an opcode whose low three bits are 100 carries a one-byte immediate, and one whose low bits are 101 carries a four-byte immediate.
- R6: These forms carry a ModR/M byte and an immediate:
  - 80, 82, 83, 6B, C0, C1 and C6 carry a one-byte immediate.
  - 81, 69 and C7 carry a four-byte immediate.
  - F6 carries a one-byte immediate and F7 a four-byte immediate, but only when the reg field is 000 or 001.
- R7: A 66 prefix shrinks four-byte immediates to two bytes and six-byte far pointers to four bytes. One-byte immediates keep their size.
- R8: Fixed-size immediates and addresses apply to these opcodes:
  - 70–7F, E0–E7, EB, 6A, A8, CD, D4 and D5 carry one byte.
  - E8, E9, 68 and A9 carry four bytes.
  - C2 and CA carry two bytes.
  - C8 carries three bytes.
  - 9A and EA carry six bytes.
  - A0–A3 carry a four-byte address, which is counted as displacement.
- R9: C5 and C4 form the VEX prefix when the next byte has bits 7:6 = 11:
  - The two or three prefix bytes count as prefix.
  - C5 implies the 0F map. For C4, bits 4:0 of the next byte select the map: 1 for 0F, 2 for 0F 38, 3 for 0F 3A; any other value is invalid.
  - One opcode byte and a ModR/M byte follow, except for 0F-map opcode 77, which has no ModR/M byte.
  - The 0F 3A map adds a one-byte immediate.
  - When the next byte has bits 7:6 ≠ 11, C4 and C5 are one-byte opcodes with a ModR/M byte.
- R10: The 67 prefix and the opcodes D6, 0F 04, 0F 0A, 0F 0C, 0F 36, 0F 39 and 0F 3B–3F raise `out_invalid`, and all counts and the length read 0.
- R11: A length above 15, or above `in_avail`, raises `out_invalid`, and all counts and the length read 0.
- R12: For a valid result, `out_len` equals the sum of the prefix, opcode, ModR/M, SIB, displacement and immediate counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window offered |
| in_ready | output | 1 | Window can be accepted |
| in_bytes | input | 120 | Window; byte k is in bits 8k+7:8k |
| in_avail | input | 4 | Number of meaningful window bytes |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 4 | Instruction length in bytes |
| out_pfx_cnt | output | 4 | Prefix bytes, including VEX |
| out_opc_cnt | output | 2 | Opcode bytes including escapes |
| out_has_modrm | output | 1 | ModR/M byte present |
| out_has_sib | output | 1 | SIB byte present |
| out_disp_cnt | output | 3 | Displacement bytes |
| out_imm_cnt | output | 3 | Immediate bytes |
| out_invalid | output | 1 | Cannot be decoded |

## Verification
Every result is due on the first rising edge after the window is accepted. The decode is purely combinational ahead of the single result register. The bench therefore changes its inputs on a falling edge and reads the outputs on the next falling edge, half a cycle after the capturing edge. In the stall test the bench holds `out_ready` low across several falling edges and checks that the earlier result is still present and `in_ready` is low. It then releases `out_ready` and expects the queued window's result one edge later.

// File: rtl/ild_pkg.sv
package ild_pkg;

    typedef enum logic [1:0] {
        MAP_ONE,
        MAP_0F,
        MAP_0F38,
        MAP_0F3A
    } opmap_e;

    typedef enum logic [2:0] {
        IMM_NONE,
        IMM_BYTE,
        IMM_WORD,
        IMM_OPSZ,
        IMM_ENTER,
        IMM_FARPTR
    } imm_kind_e;

    function automatic logic is_legacy_pfx(input logic [7:0] b);
        case (b)
            8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
            8'h26, 8'h64, 8'h65, 8'h66, 8'h67: is_legacy_pfx = 1'b1;
            default:                           is_legacy_pfx = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ild_prefix_scan.sv
module ild_prefix_scan #(
    parameter int WIN_BYTES = 15,
    parameter int IW        = 6
) (
    input  logic [WIN_BYTES*8-1:0] win,
    output logic [IW-1:0]          pfx_cnt,
    output logic                   opsize_ovr,
    output logic                   addrsize_ovr
);
    import ild_pkg::*;

    logic       run;
    logic [7:0] cur;

    always_comb begin
        pfx_cnt      = '0;
        opsize_ovr   = 1'b0;
        addrsize_ovr = 1'b0;
        run          = 1'b1;
        cur          = 8'h00;
        for (int i = 0; i < WIN_BYTES; i++) begin
            cur = win[i*8 +: 8];
            if (run && is_legacy_pfx(cur)) begin
                pfx_cnt = pfx_cnt + IW'(1);
                if (cur == 8'h66) opsize_ovr = 1'b1;
                if (cur == 8'h67) addrsize_ovr = 1'b1;
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ild_opcode_class.sv
module ild_opcode_class (
    input  ild_pkg::opmap_e map,
    input  logic [7:0]      opcode,
    input  logic [2:0]      reg_f,
    input  logic            opsize_ovr,
    output logic            has_modrm,
    output logic [2:0]      imm_len,
    output logic            moffs,
    output logic            bad
);
    import ild_pkg::*;

    imm_kind_e kind;

    always_comb begin
        has_modrm = 1'b0;
        kind      = IMM_NONE;
        moffs     = 1'b0;
        bad       = 1'b0;
        case (map)
            MAP_ONE: begin
                if (opcode < 8'h40) begin
                    case (opcode[2:0])
                        3'd0, 3'd1, 3'd2, 3'd3: has_modrm = 1'b1;
                        3'd4:                   kind = IMM_BYTE;
                        3'd5:                   kind = IMM_OPSZ;
                        default:                ;
                    endcase
                end else if (opcode < 8'h60) begin
                    kind = IMM_NONE;
                end else if (opcode >= 8'h70 && opcode <= 8'h7F) begin
                    kind = IMM_BYTE;
                end else if (opcode >= 8'h84 && opcode <= 8'h8F) begin
                    has_modrm = 1'b1;
                end else if (opcode >= 8'hB0 && opcode <= 8'hB7) begin
                    kind = IMM_BYTE;
                end else if (opcode >= 8'hB8 && opcode <= 8'hBF) begin
                    kind = IMM_OPSZ;
                end else if (opcode >= 8'hD8 && opcode <= 8'hDF) begin
                    has_modrm = 1'b1;
                end else if (opcode >= 8'hE0 && opcode <= 8'hE7) begin
                    kind = IMM_BYTE;
                end else begin
                    case (opcode)
                        8'h62, 8'h63, 8'hC4, 8'hC5, 8'hD0, 8'hD1,
                        8'hD2, 8'hD3, 8'hFE, 8'hFF:
                            has_modrm = 1'b1;
                        8'h68, 8'hA9, 8'hE8, 8'hE9:
                            kind = IMM_OPSZ;
                        8'h69, 8'h81, 8'hC7: begin
                            has_modrm = 1'b1;
                            kind      = IMM_OPSZ;
                        end
                        8'h6A, 8'hA8, 8'hCD, 8'hD4, 8'hD5, 8'hEB:
                            kind = IMM_BYTE;
                        8'h6B, 8'h80, 8'h82, 8'h83, 8'hC0, 8'hC1, 8'hC6: begin
                            has_modrm = 1'b1;
                            kind      = IMM_BYTE;
                        end
                        8'h9A, 8'hEA:
                            kind = IMM_FARPTR;
                        8'hA0, 8'hA1, 8'hA2, 8'hA3:
                            moffs = 1'b1;
                        8'hC2, 8'hCA:
                            kind = IMM_WORD;
                        8'hC8:
                            kind = IMM_ENTER;
                        8'hD6:
                            bad = 1'b1;
                        8'hF6: begin
                            has_modrm = 1'b1;
                            if (reg_f[2:1] == 2'b00) kind = IMM_BYTE;
                        end
                        8'hF7: begin
                            has_modrm = 1'b1;
                            if (reg_f[2:1] == 2'b00) kind = IMM_OPSZ;
                        end
                        default: ;
                    endcase
                end
            end
            MAP_0F: begin
                if (opcode >= 8'h80 && opcode <= 8'h8F) begin
                    kind = IMM_OPSZ;
                end else if (opcode >= 8'hC8 && opcode <= 8'hCF) begin
                    kind = IMM_NONE;
                end else begin
                    case (opcode)
                        8'h06, 8'h08, 8'h09, 8'h0B, 8'h30, 8'h31, 8'h32,
                        8'h33, 8'h34, 8'h35, 8'h37, 8'h77, 8'hA0, 8'hA1,
                        8'hA2, 8'hA8, 8'hA9, 8'hAA:
                            has_modrm = 1'b0;
                        8'h04, 8'h0A, 8'h0C, 8'h36, 8'h39, 8'h3B,
                        8'h3C, 8'h3D, 8'h3E, 8'h3F:
                            bad = 1'b1;
                        8'h70, 8'h71, 8'h72, 8'h73, 8'hA4, 8'hAC,
                        8'hBA, 8'hC2, 8'hC4, 8'hC5, 8'hC6: begin
                            has_modrm = 1'b1;
                            kind      = IMM_BYTE;
                        end
                        default:
                            has_modrm = 1'b1;
                    endcase
                end
            end
            MAP_0F38: has_modrm = 1'b1;
            default: begin
                has_modrm = 1'b1;
                kind      = IMM_BYTE;
            end
        endcase
    end

    always_comb begin
        case (kind)
            IMM_BYTE:   imm_len = 3'd1;
            IMM_WORD:   imm_len = 3'd2;
            IMM_OPSZ:   imm_len = opsize_ovr ? 3'd2 : 3'd4;
            IMM_ENTER:  imm_len = 3'd3;
            IMM_FARPTR: imm_len = opsize_ovr ? 3'd4 : 3'd6;
            default:    imm_len = 3'd0;
        endcase
    end

endmodule

// File: rtl/ild_addr_size.sv
module ild_addr_size (
    input  logic       present,
    input  logic [1:0] mod_f,
    input  logic [2:0] rm_f,
    input  logic [2:0] base_f,
    output logic       sib_cnt,
    output logic [2:0] disp_len
);
    always_comb begin
        sib_cnt  = present && (mod_f != 2'b11) && (rm_f == 3'b100);
        disp_len = 3'd0;
        if (present) begin
            case (mod_f)
                2'b01: disp_len = 3'd1;
                2'b10: disp_len = 3'd4;
                2'b00: begin
                    if ((!sib_cnt && rm_f == 3'b101) || (sib_cnt && base_f == 3'b101))
                        disp_len = 3'd4;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder #(
    parameter int WIN_BYTES = 15,
    parameter int MAX_LEN   = 15
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [WIN_BYTES*8-1:0]             in_bytes,
    input  logic [$clog2(WIN_BYTES+1)-1:0]     in_avail,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [$clog2(MAX_LEN+1)-1:0]       out_len,
    output logic [$clog2(MAX_LEN+1)-1:0]       out_pfx_cnt,
    output logic [1:0]                         out_opc_cnt,
    output logic                               out_has_modrm,
    output logic                               out_has_sib,
    output logic [2:0]                         out_disp_cnt,
    output logic [2:0]                         out_imm_cnt,
    output logic                               out_invalid
);
    import ild_pkg::*;

    localparam int LW = $clog2(MAX_LEN + 1);
    localparam int IW = $clog2(WIN_BYTES + 24);

    typedef struct packed {
        logic          vld;
        logic          bad;
        logic [LW-1:0] len;
        logic [LW-1:0] pfx;
        logic [1:0]    opc;
        logic          mr;
        logic          sib;
        logic [2:0]    disp;
        logic [2:0]    imm;
    } res_t;

    res_t st_d, st_q;

    function automatic logic [7:0] byte_at(input logic [WIN_BYTES*8-1:0] w,
                                           input logic [IW-1:0] idx);
        byte_at = 8'h00;
        for (int k = 0; k < WIN_BYTES; k++)
            if (idx == IW'(k)) byte_at = w[k*8 +: 8];
    endfunction

    logic [IW-1:0] pos, opc_pos, mr_pos, total, pfx_all;
    logic          opsize_ovr, addrsize_ovr;
    logic [7:0]    b0, b1, opcode, modrm;
    logic [2:0]    sib_base;
    logic [1:0]    vex_len, opc_len;
    opmap_e        map;
    logic          map_bad;
    logic          has_modrm, moffs, cls_bad, sib_cnt, bad_all;
    logic [2:0]    imm_len, disp_len, disp_all;

    ild_prefix_scan #(.WIN_BYTES(WIN_BYTES), .IW(IW)) u_pfx (
        .win          (in_bytes),
        .pfx_cnt      (pos),
        .opsize_ovr   (opsize_ovr),
        .addrsize_ovr (addrsize_ovr)
    );

    // Escape and VEX recognition, field positions
    always_comb begin
        b0      = byte_at(in_bytes, pos);
        b1      = byte_at(in_bytes, pos + IW'(1));
        vex_len = 2'd0;
        opc_len = 2'd1;
        map     = MAP_ONE;
        map_bad = 1'b0;
        if (b0 == 8'h0F) begin
            if (b1 == 8'h38) begin
                map     = MAP_0F38;
                opc_len = 2'd3;
            end else if (b1 == 8'h3A) begin
                map     = MAP_0F3A;
                opc_len = 2'd3;
            end else begin
                map     = MAP_0F;
                opc_len = 2'd2;
            end
        end else if ((b0 == 8'hC4 || b0 == 8'hC5) && b1[7:6] == 2'b11) begin
            if (b0 == 8'hC5) begin
                vex_len = 2'd2;
                map     = MAP_0F;
            end else begin
                vex_len = 2'd3;
                case (b1[4:0])
                    5'd1:    map = MAP_0F;
                    5'd2:    map = MAP_0F38;
                    5'd3:    map = MAP_0F3A;
                    default: map_bad = 1'b1;
                endcase
            end
        end
        opc_pos  = pos + IW'(vex_len) + IW'(opc_len) - IW'(1);
        mr_pos   = opc_pos + IW'(1);
        opcode   = byte_at(in_bytes, opc_pos);
        modrm    = byte_at(in_bytes, mr_pos);
        sib_base = 3'(byte_at(in_bytes, mr_pos + IW'(1)));
    end

    ild_opcode_class u_cls (
        .map        (map),
        .opcode     (opcode),
        .reg_f      (modrm[5:3]),
        .opsize_ovr (opsize_ovr),
        .has_modrm  (has_modrm),
        .imm_len    (imm_len),
        .moffs      (moffs),
        .bad        (cls_bad)
    );

    ild_addr_size u_addr (
        .present  (has_modrm),
        .mod_f    (modrm[7:6]),
        .rm_f     (modrm[2:0]),
        .base_f   (sib_base),
        .sib_cnt  (sib_cnt),
        .disp_len (disp_len)
    );

    // Next-state computation
    always_comb begin
        disp_all = has_modrm ? disp_len : (moffs ? 3'd4 : 3'd0);
        pfx_all  = pos + IW'(vex_len);
        total    = pfx_all + IW'(opc_len) + IW'(has_modrm) + IW'(sib_cnt)
                 + IW'(disp_all) + IW'(imm_len);
        bad_all  = cls_bad || map_bad || addrsize_ovr
                 || (total > IW'(MAX_LEN)) || (total > IW'(in_avail));
        st_d = st_q;
        if (in_valid && in_ready) begin
            st_d.vld = 1'b1;
            st_d.bad = bad_all;
            if (bad_all) begin
                st_d.len  = '0;
                st_d.pfx  = '0;
                st_d.opc  = '0;
                st_d.mr   = 1'b0;
                st_d.sib  = 1'b0;
                st_d.disp = '0;
                st_d.imm  = '0;
            end else begin
                st_d.len  = LW'(total);
                st_d.pfx  = LW'(pfx_all);
                st_d.opc  = opc_len;
                st_d.mr   = has_modrm;
                st_d.sib  = sib_cnt;
                st_d.disp = disp_all;
                st_d.imm  = imm_len;
            end
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready      = !st_q.vld || out_ready;
    assign out_valid     = st_q.vld;
    assign out_invalid   = st_q.bad;
    assign out_len       = st_q.len;
    assign out_pfx_cnt   = st_q.pfx;
    assign out_opc_cnt   = st_q.opc;
    assign out_has_modrm = st_q.mr;
    assign out_has_sib   = st_q.sib;
    assign out_disp_cnt  = st_q.disp;
    assign out_imm_cnt   = st_q.imm;

    // R1
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_invalid)
                                       && $stable(out_pfx_cnt) && $stable(out_imm_cnt)));

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R1
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R12
    len_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid) |-> (int'(out_len) == int'(out_pfx_cnt) + int'(out_opc_cnt)
            + int'(out_has_modrm) + int'(out_has_sib) + int'(out_disp_cnt) + int'(out_imm_cnt)));

    // R10
    inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_len == '0 && !out_has_modrm && out_imm_cnt == '0));

    // R11
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid) |-> (out_len != '0 && int'(out_len) <= MAX_LEN));

    // R4
    sib_needs_modrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_has_sib |-> out_has_modrm);

endmodule

// File: tb/insn_len_decoder_tb.sv
`timescale 1ns/1ps
module insn_len_decoder_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [119:0] in_bytes;
    logic [3:0]   in_avail = 4'd15;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [3:0]   out_len, out_pfx_cnt;
    logic [1:0]   out_opc_cnt;
    logic         out_has_modrm, out_has_sib, out_invalid;
    logic [2:0]   out_disp_cnt, out_imm_cnt;

    logic [7:0]   win [15];
    int           tests = 0;
    int           fails = 0;
    bit           done  = 1'b0;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < 15; i++) in_bytes[i*8 +: 8] = win[i];

    insn_len_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bytes(in_bytes), .in_avail(in_avail), .out_valid(out_valid),
        .out_ready(out_ready), .out_len(out_len), .out_pfx_cnt(out_pfx_cnt),
        .out_opc_cnt(out_opc_cnt), .out_has_modrm(out_has_modrm),
        .out_has_sib(out_has_sib), .out_disp_cnt(out_disp_cnt),
        .out_imm_cnt(out_imm_cnt), .out_invalid(out_invalid)
    );

    task automatic clr;
        for (int i = 0; i < 15; i++) win[i] = 8'h00;
    endtask

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Offer the window, then read every field one cycle later.
    task automatic go(input string tag, input int avail, input int ep, input int eo,
                      input int em, input int es, input int ed, input int ei, input bit einv);
        int el;
        @(negedge clk);
        in_avail = 4'(avail);
        in_valid = 1'b1;
        @(negedge clk);
        if (einv) begin
            ep = 0; eo = 0; em = 0; es = 0; ed = 0; ei = 0;
        end
        el = ep + eo + em + es + ed + ei;  // R12: length is the sum of the fields
        tests++;
        if (!out_valid || out_invalid != einv || int'(out_len) != el || int'(out_pfx_cnt) != ep
            || int'(out_opc_cnt) != eo || int'(out_has_modrm) != em || int'(out_has_sib) != es
            || int'(out_disp_cnt) != ed || int'(out_imm_cnt) != ei) begin
            fails++;
            $display("FAIL %s: actual v%0d inv%0d len%0d p%0d o%0d m%0d s%0d d%0d i%0d expected v1 inv%0d len%0d p%0d o%0d m%0d s%0d d%0d i%0d",
                     tag, out_valid, out_invalid, out_len, out_pfx_cnt, out_opc_cnt, out_has_modrm,
                     out_has_sib, out_disp_cnt, out_imm_cnt, einv, el, ep, eo, em, es, ed, ei);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog expired: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] plist [10];
        plist = '{8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65, 8'h66};
        clr();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset out_valid", out_valid == 1'b0, out_valid, 0);
        check("R1 reset in_ready", in_ready == 1'b1, in_ready, 1);
        rst_n = 1'b1;

        // R2 prefix run lengths
        for (int p = 0; p <= 15; p++) begin
            clr();
            for (int i = 0; i < p; i++) win[i] = plist[i % 10];
            if (p < 15) win[p] = 8'h90;
            go("R2 prefix run", 15, p, 1, 0, 0, 0, 0, (p + 1 > 15));
        end

        // R3 opcode maps
        clr(); win[0] = 8'h0F; win[1] = 8'hB6; win[2] = 8'hC0;
        go("R3 0F B6 reg", 15, 0, 2, 1, 0, 0, 0, 0);
        clr(); win[0] = 8'h0F; win[1] = 8'h38; win[2] = 8'h00; win[3] = 8'hC1;
        go("R3 0F38 map", 15, 0, 3, 1, 0, 0, 0, 0);
        clr(); win[0] = 8'h0F; win[1] = 8'h3A; win[2] = 8'h0F; win[3] = 8'hC1; win[4] = 8'h08;
        go("R3 0F3A map imm8", 15, 0, 3, 1, 0, 0, 1, 0);
        clr(); win[0] = 8'h0F; win[1] = 8'hA2;
        go("R3 0F A2 bare", 15, 0, 2, 0, 0, 0, 0, 0);
        clr(); win[0] = 8'h0F; win[1] = 8'h84;
        go("R3 0F 84 rel32", 15, 0, 2, 0, 0, 0, 4, 0);
        clr(); win[0] = 8'h66; win[1] = 8'h0F; win[2] = 8'h84;
        go("R7 66 0F 84 rel16", 15, 1, 2, 0, 0, 0, 2, 0);

        // R4 addressing sweep over every ModR/M value, two SIB bases
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 256; m++) begin
                int md, rm, sb, ds, base;
                clr();
                base = (s == 0) ? 5 : 0;
                win[0] = 8'h8B; win[1] = 8'(m); win[2] = 8'(8'h20 | base);
                md = m >> 6; rm = m & 7;
                sb = (md != 3 && rm == 4) ? 1 : 0;
                if (md == 1) ds = 1;
                else if (md == 2) ds = 4;
                else if (md == 0 && ((sb == 0 && rm == 5) || (sb == 1 && base == 5))) ds = 4;
                else ds = 0;
                go("R4 modrm sweep", 15, 0, 1, 1, sb, ds, 0, 0);
            end
        end

        // R5 short forms
        for (int op = 8'h40; op <= 8'h5F; op++) begin
            clr(); win[0] = 8'(op);
            go("R5 inc/dec/push/pop", 15, 0, 1, 0, 0, 0, 0, 0);
        end
        for (int op = 8'h90; op <= 8'h97; op++) begin
            clr(); win[0] = 8'(op);
            go("R5 xchg eax", 15, 0, 1, 0, 0, 0, 0, 0);
        end
        for (int op = 8'hB0; op <= 8'hBF; op++) begin
            clr(); win[0] = 8'(op);
            go("R5 mov reg imm", 15, 0, 1, 0, 0, 0, (op < 8'hB8) ? 1 : 4, 0);
        end
        for (int r = 0; r < 8; r++) begin
            clr(); win[0] = 8'(r * 8 + 4);
            go("R5 acc imm8", 15, 0, 1, 0, 0, 0, 1, 0);
            clr(); win[0] = 8'(r * 8 + 5);
            go("R5 acc imm32", 15, 0, 1, 0, 0, 0, 4, 0);
            clr(); win[0] = 8'h66; win[1] = 8'(r * 8 + 5);
            go("R7 acc imm16", 15, 1, 1, 0, 0, 0, 2, 0);
        end
        clr(); win[0] = 8'h66; win[1] = 8'hB8;
        go("R7 66 B8", 15, 1, 1, 0, 0, 0, 2, 0);

        // R6 ModR/M plus immediate
        clr(); win[0] = 8'h83; win[1] = 8'hC0;
        go("R6 83 imm8", 15, 0, 1, 1, 0, 0, 1, 0);
        clr(); win[0] = 8'h81; win[1] = 8'hC0;
        go("R6 81 imm32", 15, 0, 1, 1, 0, 0, 4, 0);
        clr(); win[0] = 8'h69; win[1] = 8'hC0;
        go("R6 69 imm32", 15, 0, 1, 1, 0, 0, 4, 0);
        clr(); win[0] = 8'h80; win[1] = 8'h00;
        go("R6 80 mem imm8", 15, 0, 1, 1, 0, 0, 1, 0);
        clr(); win[0] = 8'hF6; win[1] = 8'hC0;
        go("R6 F6 reg0 imm8", 15, 0, 1, 1, 0, 0, 1, 0);
        clr(); win[0] = 8'hF6; win[1] = 8'hD0;
        go("R6 F6 reg2 no imm", 15, 0, 1, 1, 0, 0, 0, 0);
        clr(); win[0] = 8'hF7; win[1] = 8'hC8;
        go("R6 F7 reg1 imm32", 15, 0, 1, 1, 0, 0, 4, 0);
        clr(); win[0] = 8'hF7; win[1] = 8'hD8;
        go("R6 F7 reg3 no imm", 15, 0, 1, 1, 0, 0, 0, 0);
        clr(); win[0] = 8'hC6; win[1] = 8'h05;
        go("R6 C6 abs disp imm8", 15, 0, 1, 1, 0, 4, 1, 0);
        clr(); win[0] = 8'h66; win[1] = 8'h81; win[2] = 8'hC0;
        go("R7 66 81 imm16", 15, 1, 1, 1, 0, 0, 2, 0);
        clr(); win[0] = 8'h66; win[1] = 8'h83; win[2] = 8'hC0;
        go("R7 66 83 imm8 kept", 15, 1, 1, 1, 0, 0, 1, 0);

        // R8 fixed immediates
        clr(); win[0] = 8'h75;
        go("R8 jcc rel8", 15, 0, 1, 0, 0, 0, 1, 0);
        clr(); win[0] = 8'hE8;
        go("R8 call rel32", 15, 0, 1, 0, 0, 0, 4, 0);
        clr(); win[0] = 8'hC2;
        go("R8 ret imm16", 15, 0, 1, 0, 0, 0, 2, 0);
        clr(); win[0] = 8'hC8;
        go("R8 enter", 15, 0, 1, 0, 0, 0, 3, 0);
        clr(); win[0] = 8'h9A;
        go("R8 far call", 15, 0, 1, 0, 0, 0, 6, 0);
        clr(); win[0] = 8'h66; win[1] = 8'hEA;
        go("R7 66 far jmp", 15, 1, 1, 0, 0, 0, 4, 0);
        clr(); win[0] = 8'hA1;
        go("R8 moffs", 15, 0, 1, 0, 0, 4, 0, 0);

        // R9 VEX forms
        clr(); win[0] = 8'hC5; win[1] = 8'hF8; win[2] = 8'h58; win[3] = 8'hC1;
        go("R9 vex2", 15, 2, 1, 1, 0, 0, 0, 0);
        clr(); win[0] = 8'hC4; win[1] = 8'hE3; win[2] = 8'h79; win[3] = 8'h0F; win[4] = 8'hC1;
        go("R9 vex3 0F3A imm8", 15, 3, 1, 1, 0, 0, 1, 0);
        clr(); win[0] = 8'hC4; win[1] = 8'hE2; win[2] = 8'h7D; win[3] = 8'h18; win[4] = 8'h04;
        win[5] = 8'h24;
        go("R9 vex3 0F38 sib", 15, 3, 1, 1, 1, 0, 0, 0);
        clr(); win[0] = 8'hC5; win[1] = 8'hF8; win[2] = 8'h77;
        go("R9 vex 77 no modrm", 15, 2, 1, 0, 0, 0, 0, 0);
        clr(); win[0] = 8'hC4; win[1] = 8'hE4; win[2] = 8'h7D; win[3] = 8'h00; win[4] = 8'hC0;
        go("R9 vex bad map", 15, 0, 0, 0, 0, 0, 0, 1);
        clr(); win[0] = 8'hC5; win[1] = 8'h06;
        go("R9 C5 as opcode", 15, 0, 1, 1, 0, 0, 0, 0);
        clr(); win[0] = 8'hC4; win[1] = 8'h45;
        go("R9 C4 as opcode", 15, 0, 1, 1, 0, 1, 0, 0);

        // R10 undecodable
        clr(); win[0] = 8'h67; win[1] = 8'h8B; win[2] = 8'h00;
        go("R10 addr override", 15, 0, 0, 0, 0, 0, 0, 1);
        clr(); win[0] = 8'hD6;
        go("R10 D6", 15, 0, 0, 0, 0, 0, 0, 1);
        clr(); win[0] = 8'h0F; win[1] = 8'h0A;
        go("R10 0F 0A", 15, 0, 0, 0, 0, 0, 0, 1);

        // R11 window and length limits
        for (int a = 0; a <= 15; a++) begin
            clr();
            win[0] = 8'h81; win[1] = 8'h80;
            for (int i = 2; i < 10; i++) win[i] = 8'(i * 17);
            go("R11 avail sweep", a, 0, 1, 1, 0, 4, 4, (a < 10));
        end
        clr();
        for (int i = 0; i < 14; i++) win[i] = 8'h2E;
        win[14] = 8'h81;
        go("R11 over fifteen", 15, 0, 0, 0, 0, 0, 0, 1);

        // R12 all fields at once
        clr(); win[0] = 8'h66; win[1] = 8'hF0; win[2] = 8'h81; win[3] = 8'h84; win[4] = 8'h24;
        go("R12 full mix", 15, 2, 1, 1, 1, 4, 2, 0);

        // R1 stall behaviour
        clr(); win[0] = 8'h90;
        @(negedge clk);
        out_ready = 1'b0;
        go("R1 stall first", 15, 0, 1, 0, 0, 0, 0, 0);
        clr(); win[0] = 8'hB8;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 stall ready low", in_ready == 1'b0, in_ready, 0);
            check("R1 stall len held", out_len == 4'd1 && out_valid, out_len, 1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check("R1 queued result", out_valid && out_len == 4'd5, out_len, 5);
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 drained", out_valid == 1'b0, out_valid, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule